// File: doc/BRIEF.md
# Single-Wire Pulse-Width Command Receiver

This block is the peripheral end of a link that uses one bidirectional wire. It measures how long the synchronized wire stays high. A long pulse copies a parallel input word into a parallel-to-serial register. A medium pulse moves that register on by one bit. Any shorter pulse is ignored. The most significant register bit drives the wire weakly through `ser_o`. A host that briefly stops driving the wire therefore reads the current bit. A release is kept short enough that the receiver never treats it as a command.

Each high pulse is timed from zero. The count clears the moment the synchronized line reads low. A long pulse asserts the active-low load strobe as soon as the pulse reaches the long threshold, while the wire is still high. A medium pulse is classified when its falling edge arrives, and it then yields a single shift strobe. The register has a serial input at its least significant end. Several receivers can be chained so that more than `WIDTH` inputs are read over the same wire.

Top module: `pwcmd_rx`

## Requirements
- R1: While reset is active and on the first cycle after it, `load_n_o` is 1, `shift_o` is 0 and `ser_o` is 0.
- R2: A high pulse of at least `LONG_CYC` clock cycles at `line_i` drives `load_n_o` low while `line_i` is still high. `load_n_o` stays high while the pulse is shorter than `LONG_CYC`, and returns high after the line falls.
- R3: While `load_n_o` is low, the register captures `par_i`. From the next cycle on, `ser_o` equals `par_i[WIDTH-1]` as sampled during the load.
- R4: A high pulse lasting from `SHORT_CYC` to `LONG_CYC-1` cycles, both ends included, gives exactly one `shift_o` pulse one clock wide after the line falls, and no load.
- R5: Each shift moves the register one place toward the most significant bit. After k shifts following a load, `ser_o` shows bit `WIDTH-1-k` of the loaded word.
- R6: Each shift takes `ser_i` into bit 0. After `WIDTH` shifts, `ser_o` presents the `ser_i` values in the order they were shifted in.
- R7: A high pulse shorter than `SHORT_CYC` cycles produces no shift and no load, and leaves `ser_o` unchanged. This includes pulses below one third of `SHORT_CYC`.
- R8: Any low interval, even a single cycle, restarts the pulse measurement from zero. Two sub-threshold pulses separated by one low cycle therefore produce nothing.
- R9: `shift_o` is never high while `load_n_o` is low, and never high in the cycle after `load_n_o` was low.
- R10: Changes on `par_i` without a load have no effect on `ser_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled level of the shared wire, asynchronous |
| par_i | input | WIDTH | Parallel word, such as switch inputs |
| ser_i | input | 1 | Cascade input from the next register's `ser_o` |
| ser_o | output | 1 | Current register MSB, weak drive onto the wire |
| load_n_o | output | 1 | Active-low parallel-load strobe |
| shift_o | output | 1 | One-cycle shift strobe |

## Verification
Some properties are checked on every cycle:
- Load and shift stay mutually exclusive, and a shift never directly follows a load cycle.
- A shift strobe lasts one cycle.
- A load delivers the sampled MSB of `par_i` to `ser_o`.
- `ser_o` holds steady whenever neither strobe was active.

Other behaviours can only be shown by the bench's pulse scenarios:
- The pulse-length boundaries at `SHORT_CYC-1`, `SHORT_CYC`, `LONG_CYC-1` and `LONG_CYC`.
- The early load while the line is still high.
- The bit order out of the register and the cascade input.
- The restart of the count after a one-cycle low.

// File: rtl/pwcmd_pkg.sv
package pwcmd_pkg;

    // Pulse-length class, judged on the count reached before the line fell.
    typedef enum logic [1:0] {
        PW_NONE  = 2'd0,
        PW_SHIFT = 2'd1,
        PW_LOAD  = 2'd2
    } pw_class_e;

    function automatic pw_class_e pw_classify(input int len, input int short_cyc,
                                              input int long_cyc);
        if (len >= long_cyc)       return PW_LOAD;
        else if (len >= short_cyc) return PW_SHIFT;
        else                       return PW_NONE;
    endfunction

endpackage

// File: rtl/pwcmd_sync.sv
module pwcmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] ff;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ff = {st_q.ff[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.ff[STAGES-1];
endmodule

// File: rtl/pwcmd_timer.sv
module pwcmd_timer
    import pwcmd_pkg::*;
#(
    parameter int SHORT_CYC = 3000,
    parameter int LONG_CYC  = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s_i,
    output logic load_act_o,
    output logic shift_o
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] CNT_SAT = CW'(LONG_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          shift;
    } tmr_st_t;

    tmr_st_t   st_d, st_q;
    pw_class_e cls;

    always_comb begin
        st_d = st_q;
        cls  = pw_classify(int'(st_q.cnt), SHORT_CYC, LONG_CYC);
        // Count high cycles, saturate at the long threshold, clear on any low.
        if (line_s_i) begin
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        // Falling edge: the line is low now and the count is not yet cleared.
        st_d.shift = !line_s_i && (cls == PW_SHIFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_act_o = (st_q.cnt == CNT_SAT);
    assign shift_o    = st_q.shift;
endmodule

// File: rtl/pwcmd_shreg.sv
module pwcmd_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic             ser_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } sr_st_t;

    sr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sr = par_i;               // load wins; shifting inhibited
        end else if (shift_i) begin
            st_d.sr = {st_q.sr[WIDTH-2:0], ser_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_o = st_q.sr[WIDTH-1];
endmodule

// File: rtl/pwcmd_rx.sv
module pwcmd_rx #(
    parameter int WIDTH     = 8,
    parameter int SHORT_CYC = 3000,
    parameter int LONG_CYC  = 20000,
    parameter int SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic             ser_o,
    output logic             load_n_o,
    output logic             shift_o
);
    logic line_s;
    logic load_act;
    logic shift_stb;

    pwcmd_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (line_s)
    );

    pwcmd_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_s_i   (line_s),
        .load_act_o (load_act),
        .shift_o    (shift_stb)
    );

    // The register advances on the clock edge that ends the shift strobe.
    pwcmd_shreg #(.WIDTH(WIDTH)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_act),
        .shift_i (shift_stb),
        .par_i   (par_i),
        .ser_i   (ser_i),
        .ser_o   (ser_o)
    );

    assign load_n_o = ~load_act;
    assign shift_o  = shift_stb;
endmodule

// File: rtl/pwcmd_rx_chk.sv
module pwcmd_rx_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] par_i,
    input logic             ser_o,
    input logic             load_n_o,
    input logic             shift_o
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (load_n_o && !shift_o && !ser_o));

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_o && !load_n_o));

    assert_no_shift_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |-> $past(load_n_o));

    assert_single_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> !shift_o);

    assert_load_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_o |=> (ser_o == $past(par_i[WIDTH-1])));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_n_o) && !$past(shift_o)) |-> $stable(ser_o));
endmodule

bind pwcmd_rx pwcmd_rx_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_i    (par_i),
    .ser_o    (ser_o),
    .load_n_o (load_n_o),
    .shift_o  (shift_o)
);

// File: tb/pwcmd_rx_test.sv
module pwcmd_rx_test;
    localparam int W  = 8;
    localparam int SH = 30;
    localparam int LG = 200;

    logic clk = 1'b0, rst_n = 1'b0, line = 1'b0, ser_i = 1'b0;
    logic [W-1:0] par = '0;
    logic ser_o, load_n, shift_o;

    pwcmd_rx #(.WIDTH(W), .SHORT_CYC(SH), .LONG_CYC(LG)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line), .par_i(par), .ser_i(ser_i),
        .ser_o(ser_o), .load_n_o(load_n), .shift_o(shift_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        string tag;
        logic  exp_bit;
        int    exp_shifts;
        int    exp_loads;
        logic  exp_load_n;
    } item_t;

    item_t q[$];
    int checks = 0, fails = 0;
    int shifts_seen = 0, loads_seen = 0, overlap = 0;
    logic prev_load_n = 1'b1;
    logic [W-1:0] mdl = '0;
    int exp_shifts = 0, exp_loads = 0;

    // Event counters sampled mid-cycle
    always @(negedge clk) begin
        if (shift_o === 1'b1) shifts_seen++;
        if (prev_load_n === 1'b1 && load_n === 1'b0) loads_seen++;
        if (shift_o === 1'b1 && load_n === 1'b0) overlap++;
        prev_load_n = load_n;
    end

    // Monitor: pops expected items and compares
    initial forever begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (ser_o !== it.exp_bit || shifts_seen != it.exp_shifts ||
                loads_seen != it.exp_loads || load_n !== it.exp_load_n) begin
                fails++;
                $display("FAIL %s: ser_o=%b/%b shifts=%0d/%0d loads=%0d/%0d load_n=%b/%b (actual/expected)",
                         it.tag, ser_o, it.exp_bit, shifts_seen, it.exp_shifts,
                         loads_seen, it.exp_loads, load_n, it.exp_load_n);
            end
        end
    end

    task automatic push(input string tag, input logic ln);
        q.push_back('{tag, mdl[W-1], exp_shifts, exp_loads, ln});
    endtask

    task automatic pulse(input int n);
        @(negedge clk) line = 1'b1;
        repeat (n) @(negedge clk);
        line = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_shift(input int n, input string tag);
        pulse(n);
        mdl = {mdl[W-2:0], ser_i};
        exp_shifts++;
        push(tag, 1'b1);
    endtask

    task automatic no_op(input int n, input string tag);
        pulse(n);
        push(tag, 1'b1);
    endtask

    task automatic do_load(input logic [W-1:0] v, input string tag);
        par = v;
        @(negedge clk) line = 1'b1;
        repeat (LG - 5) @(negedge clk);
        push({tag, " R2 not yet loaded"}, 1'b1);
        repeat (11) @(negedge clk);
        mdl = v;
        exp_loads++;
        push({tag, " R2 load while high"}, 1'b0);
        line = 1'b0;
        repeat (8) @(negedge clk);
        push({tag, " R3 loaded MSB"}, 1'b1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        push("R1 during reset", 1'b1);
        @(negedge clk) rst_n = 1'b1;
        push("R1 after reset", 1'b1);
        repeat (3) @(negedge clk);

        do_load(8'hA5, "load A5");
        ser_i = 1'b1;
        do_shift(SH, "R4 lower bound shift / R5 bit6");
        do_shift(LG - 1, "R4 upper bound shift / R5 bit5");
        no_op(SH - 1, "R7 just below short");
        no_op(SH / 3, "R7 one third short");
        no_op(1, "R7 one-cycle pulse");

        // R8: split pulse, each half below threshold
        @(negedge clk) line = 1'b1;
        repeat (SH - 5) @(negedge clk);
        line = 1'b0;
        @(negedge clk) line = 1'b1;
        repeat (SH - 5) @(negedge clk);
        line = 1'b0;
        repeat (8) @(negedge clk);
        push("R8 restart after one low cycle", 1'b1);

        par = 8'h00;
        repeat (3) @(negedge clk);
        push("R10 par change without load", 1'b1);

        for (int k = 0; k < 6; k++) begin
            ser_i = k[0];
            do_shift(100, "R5/R6 shift sequence");
        end

        // Exactly LONG_CYC counts as a load
        par = 8'h3C;
        pulse(LG);
        mdl = 8'h3C;
        exp_loads++;
        push("R2 exact long threshold load / R3", 1'b1);

        do_load(8'h5A, "load 5A");
        for (int k = 0; k < W + 2; k++) begin
            ser_i = (k % 3 == 0);
            do_shift(SH + k, "R5 bit order / R6 cascade");
        end

        repeat (5) @(negedge clk);
        checks++;
        if (overlap != 0) begin
            fails++;
            $display("FAIL R9: overlap cycles=%0d expected 0", overlap);
        end
        finish_run();
    end
endmodule